// File: doc/BRIEF.md
# Tone-Burst Cassette Bit Codec

This block records and plays back blocks of bytes in a tape format where every bit is made of tone and silence. A bit period has three equal thirds. The opening third always carries tone. The closing third is always silent. The centre third carries tone for a one and silence for a zero. The transmit side sends a run of one-bits as a leader, then a single zero that marks the start of the data, then the block bytes, then a 16-bit checksum. It drives a tone-enable pin that an analog oscillator would gate.

The receive side takes a squared tone-present signal, for example from a comparator after an envelope detector. It decides each bit by comparing how long the tone lasted with how long the silence after it lasted. Absolute timing is never used, so the decoder copes with tape running fast or slow. The receiver waits until it sees a complete leader and the zero marker. It then reassembles the bytes, presents the data bytes on a strobe, and verifies the checksum at the end of the block.

Bytes enter through a valid/ready stream. A byte moves on a clock edge where `s_valid` and `s_ready` are both high. The block holds one byte in reserve and stalls `s_ready` while that slot is full. The source must keep `s_valid` high whenever `s_ready` is high until the block's last byte has gone in. A late byte leaves silence on the line, and the line cannot tell that silence from a pause. Decoded bytes leave on a strobe with no ready signal, because a tape cannot be paused, so the sink must take every strobed byte.

Top module: `cas_codec`

## Requirements
- R1: Every transmitted bit lasts BIT_CYC clock cycles, made of three thirds of BIT_CYC/3 cycles each. `tone_out` is high in the first third and low in the last third. In the middle third `tone_out` equals the bit value.
- R2: A transmitted block consists of, in order: LEADER_LEN one-bits, one zero-bit, the BLOCK_BYTES data bytes each sent least significant bit first with no gap bits, the checksum low byte, the checksum high byte, and finally one bit period whose first third is tone and whose rest is silence.
- R3: The checksum is a 16-bit CRC over the data bytes. It is bit-reflected with polynomial 0x8005 (0xA001 when shifted right), starts from zero and has no final inversion. Running the same CRC over the data followed by both checksum bytes therefore leaves zero.
- R4: `s_ready` is high after reset. It is low whenever the single reserve slot is full, and it stays low from the acceptance of the BLOCK_BYTES-th byte until `tx_busy` falls. The first accepted byte starts the leader. While `tx_busy` is low, `tone_out` is low.
- R5: The receiver decodes a bit as 1 exactly when its tone time is longer than the silence that follows it, and as 0 otherwise. Blocks whose thirds differ from BIT_CYC/3 decode the same way.
- R6: The receiver enters data framing only after LEADER_LEN consecutive decoded one-bits followed by a zero. A zero seen before the count is complete restarts the count, and nothing is output.
- R7: Each decoded data byte appears on `m_data` with a one-cycle `m_valid` strobe, in transmission order. The two checksum bytes are never strobed.
- R8: After the high checksum byte is decoded, `block_done` pulses for one cycle. `crc_error` is high in that same cycle exactly when the CRC over data and checksum bytes is non-zero, and it is low in every other cycle.
- R9: Once the leader has been accepted, a gap of 4*BIT_CYC cycles with no tone edge makes `rx_abort` pulse for one cycle. The receiver then returns to leader search without `block_done`. A gap during leader search does not pulse `rx_abort`.
- R10: After reset, `s_ready` is 1, and `tone_out`, `tx_busy`, `m_valid`, `block_done`, `crc_error` and `rx_abort` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Byte to record is valid |
| s_ready | output | 1 | Codec takes a byte this cycle |
| s_data | input | 8 | Byte to record |
| tone_out | output | 1 | Tone enable for the recording oscillator |
| tx_busy | output | 1 | A block is being sent |
| tone_in | input | 1 | Squared tone-present signal from playback |
| m_valid | output | 1 | One-cycle strobe for a decoded data byte |
| m_data | output | 8 | Decoded data byte |
| block_done | output | 1 | One-cycle pulse when a whole block was read |
| crc_error | output | 1 | With block_done: checksum residue is non-zero |
| rx_abort | output | 1 | One-cycle pulse when playback stopped mid-block |

## Verification
The bench builds the codec with BIT_CYC = 6, which gives two-cycle thirds, a LEADER_LEN of 8 and a BLOCK_BYTES of 4. With these values whole blocks, the checksum tail, the leader restart and the mid-block time-out each take only a few hundred cycles. The same parameters leave the decision rules unchanged. Besides looping the transmitter back into the receiver, the bench plays hand-built waveforms with thirds of 3 and 7 cycles, a corrupted checksum, a leader one bit short, and a block cut off part way.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [2:0] {
    TX_IDLE, TX_LEAD, TX_MARK, TX_DATA, TX_WAIT, TX_TAIL
  } tx_state_t;

  typedef enum logic [1:0] {
    RX_HUNT, RX_SYNC, RX_DATA
  } rx_state_t;

  // Reflected CRC-16, polynomial 0x8005 (0xA001 shifted form), byte fed LSB first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 16'hA001;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/cas_tx.sv
module cas_tx
  import cas_pkg::*;
#(
  parameter int BIT_CYC     = 3000,
  parameter int LEADER_LEN  = 250,
  parameter int BLOCK_BYTES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  output logic       tone_out,
  output logic       busy
);
  localparam int PW = $clog2(BIT_CYC);
  localparam int LW = $clog2(LEADER_LEN + 1);
  localparam int BW = $clog2(BLOCK_BYTES + 3);
  localparam logic [PW-1:0] PH_LAST = PW'(BIT_CYC - 1);
  localparam logic [PW-1:0] TH1     = PW'(BIT_CYC / 3);
  localparam logic [PW-1:0] TH2     = PW'(2 * (BIT_CYC / 3));
  localparam logic [LW-1:0] LLEN    = LW'(LEADER_LEN);
  localparam logic [BW-1:0] BLK     = BW'(BLOCK_BYTES);
  localparam logic [BW-1:0] BLK1    = BW'(BLOCK_BYTES + 1);

  tx_state_t     state;
  logic [PW-1:0] ph;
  logic          cur_bit;
  logic [7:0]    sh;
  logic [2:0]    bidx;
  logic [LW-1:0] lcnt;
  logic [BW-1:0] snd_cnt, acc_cnt;
  logic [7:0]    hold;
  logic          hold_v;
  logic [15:0]   crc;

  logic       bit_end, load_go, accept, consume;
  logic       nb_avail, nb_is_data, nb_end;
  logic [7:0] nb;

  assign bit_end = (ph == PH_LAST);
  assign s_ready = !hold_v && (acc_cnt < BLK);
  assign accept  = s_valid && s_ready;
  assign busy    = (state != TX_IDLE);

  // Source of the next byte to serialize: data reserve, then CRC low, CRC high
  always_comb begin
    nb_avail   = 1'b0;
    nb_is_data = 1'b0;
    nb_end     = 1'b0;
    nb         = hold;
    if (snd_cnt < BLK) begin
      nb_avail   = hold_v;
      nb_is_data = 1'b1;
    end else if (snd_cnt == BLK) begin
      nb_avail = 1'b1;
      nb       = crc[7:0];
    end else if (snd_cnt == BLK1) begin
      nb_avail = 1'b1;
      nb       = crc[15:8];
    end else begin
      nb_end = 1'b1;
    end
  end

  assign load_go = (bit_end && (state == TX_MARK || (state == TX_DATA && bidx == 3'd7)))
                   || (state == TX_WAIT);
  assign consume = load_go && nb_avail && nb_is_data;

  always_comb begin
    tone_out = 1'b0;
    if (state == TX_LEAD || state == TX_MARK || state == TX_DATA)
      tone_out = (ph < TH1) || (cur_bit && (ph < TH2));
    else if (state == TX_TAIL)
      tone_out = (ph < TH1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      ph      <= '0;
      cur_bit <= 1'b0;
      sh      <= '0;
      bidx    <= '0;
      lcnt    <= '0;
      snd_cnt <= '0;
      acc_cnt <= '0;
      hold    <= '0;
      hold_v  <= 1'b0;
      crc     <= '0;
    end else begin
      if (accept) begin
        hold    <= s_data;
        acc_cnt <= acc_cnt + 1'b1;
        crc     <= crc16_byte(crc, s_data);
      end
      if (accept)       hold_v <= 1'b1;
      else if (consume) hold_v <= 1'b0;

      case (state)
        TX_IDLE: begin
          ph <= '0;
          if (hold_v) begin
            state   <= TX_LEAD;
            cur_bit <= 1'b1;
            lcnt    <= LW'(1);
          end
        end
        TX_LEAD: begin
          if (!bit_end) ph <= ph + 1'b1;
          else begin
            ph <= '0;
            if (lcnt == LLEN) begin
              state   <= TX_MARK;
              cur_bit <= 1'b0;
            end else begin
              lcnt <= lcnt + 1'b1;
            end
          end
        end
        TX_MARK, TX_DATA: begin
          if (!bit_end) ph <= ph + 1'b1;
          else if (state == TX_DATA && bidx != 3'd7) begin
            ph      <= '0;
            bidx    <= bidx + 1'b1;
            sh      <= sh >> 1;
            cur_bit <= sh[1];
          end
        end
        TX_TAIL: begin
          if (!bit_end) ph <= ph + 1'b1;
          else begin
            state   <= TX_IDLE;
            ph      <= '0;
            snd_cnt <= '0;
            acc_cnt <= '0;
            crc     <= '0;
          end
        end
        default: ;
      endcase

      if (load_go) begin
        ph <= '0;
        if (nb_end) begin
          state <= TX_TAIL;
        end else if (nb_avail) begin
          state   <= TX_DATA;
          sh      <= nb;
          cur_bit <= nb[0];
          bidx    <= '0;
          snd_cnt <= snd_cnt + 1'b1;
        end else begin
          state <= TX_WAIT;
        end
      end
    end
  end

endmodule

// File: rtl/cas_bitdet.sv
module cas_bitdet #(
  parameter int BIT_CYC = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tone_in,
  output logic bit_v,
  output logic bit_val,
  output logic stall
);
  localparam int TOUT = 4 * BIT_CYC;
  localparam int CW   = $clog2(TOUT + 1);
  localparam logic [CW-1:0] CMAX     = CW'(TOUT);
  localparam logic [CW-1:0] GAP_LAST = CW'(TOUT - 1);

  logic          s1, s2, s3, pend;
  logic [CW-1:0] tone_cnt, pause_cnt, gap_cnt;
  logic          rise, fall;

  assign rise = s2 && !s3;
  assign fall = !s2 && s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1        <= 1'b0;
      s2        <= 1'b0;
      s3        <= 1'b0;
      pend      <= 1'b0;
      tone_cnt  <= '0;
      pause_cnt <= '0;
      gap_cnt   <= '0;
      bit_v     <= 1'b0;
      bit_val   <= 1'b0;
      stall     <= 1'b0;
    end else begin
      s1    <= tone_in;
      s2    <= s1;
      s3    <= s2;
      bit_v <= 1'b0;
      stall <= 1'b0;

      if (rise || fall)       gap_cnt <= '0;
      else if (gap_cnt != CMAX) gap_cnt <= gap_cnt + 1'b1;

      if (rise) begin
        tone_cnt <= CW'(1);
        if (pend) begin
          bit_v   <= 1'b1;
          bit_val <= (tone_cnt > pause_cnt);
          pend    <= 1'b0;
        end
      end else if (s2) begin
        if (tone_cnt != CMAX) tone_cnt <= tone_cnt + 1'b1;
      end

      if (fall) begin
        pause_cnt <= CW'(1);
        pend      <= 1'b1;
      end else if (!s2) begin
        if (pause_cnt != CMAX) pause_cnt <= pause_cnt + 1'b1;
        // silence already as long as the tone: the bit is a zero
        if (pend && pause_cnt >= tone_cnt) begin
          bit_v   <= 1'b1;
          bit_val <= 1'b0;
          pend    <= 1'b0;
        end
      end

      if (gap_cnt == GAP_LAST && !(rise || fall)) begin
        stall <= 1'b1;
        pend  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cas_rxframe.sv
module cas_rxframe
  import cas_pkg::*;
#(
  parameter int LEADER_LEN  = 250,
  parameter int BLOCK_BYTES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_v,
  input  logic       bit_val,
  input  logic       stall,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       block_done,
  output logic       crc_error,
  output logic       rx_abort
);
  localparam int LW = $clog2(LEADER_LEN + 1);
  localparam int BW = $clog2(BLOCK_BYTES + 3);
  localparam logic [LW-1:0] LLAST = LW'(LEADER_LEN - 1);
  localparam logic [BW-1:0] BLK   = BW'(BLOCK_BYTES);
  localparam logic [BW-1:0] BLK1  = BW'(BLOCK_BYTES + 1);

  rx_state_t     st;
  logic [LW-1:0] lcnt;
  logic [7:0]    sh;
  logic [2:0]    bidx;
  logic [BW-1:0] rcnt;
  logic [15:0]   crc;

  logic [7:0]  nbyte;
  logic [15:0] crc_nxt;

  assign nbyte   = {bit_val, sh[7:1]};
  assign crc_nxt = crc16_byte(crc, nbyte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= RX_HUNT;
      lcnt       <= '0;
      sh         <= '0;
      bidx       <= '0;
      rcnt       <= '0;
      crc        <= '0;
      m_valid    <= 1'b0;
      m_data     <= '0;
      block_done <= 1'b0;
      crc_error  <= 1'b0;
      rx_abort   <= 1'b0;
    end else begin
      m_valid    <= 1'b0;
      block_done <= 1'b0;
      crc_error  <= 1'b0;
      rx_abort   <= 1'b0;
      case (st)
        RX_HUNT: begin
          if (stall) lcnt <= '0;
          else if (bit_v) begin
            if (!bit_val) lcnt <= '0;
            else if (lcnt == LLAST) begin
              st   <= RX_SYNC;
              lcnt <= '0;
            end else lcnt <= lcnt + 1'b1;
          end
        end
        RX_SYNC: begin
          if (stall) begin
            st       <= RX_HUNT;
            rx_abort <= 1'b1;
          end else if (bit_v && !bit_val) begin
            st   <= RX_DATA;
            bidx <= '0;
            rcnt <= '0;
            crc  <= '0;
          end
        end
        RX_DATA: begin
          if (stall) begin
            st       <= RX_HUNT;
            rx_abort <= 1'b1;
          end else if (bit_v) begin
            sh   <= nbyte;
            bidx <= bidx + 1'b1;
            if (bidx == 3'd7) begin
              crc  <= crc_nxt;
              rcnt <= rcnt + 1'b1;
              if (rcnt < BLK) begin
                m_valid <= 1'b1;
                m_data  <= nbyte;
              end
              if (rcnt == BLK1) begin
                block_done <= 1'b1;
                crc_error  <= (crc_nxt != 16'h0000);
                st         <= RX_HUNT;
                lcnt       <= '0;
              end
            end
          end
        end
        default: st <= RX_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/cas_codec.sv
module cas_codec #(
  parameter int BIT_CYC     = 3000,
  parameter int LEADER_LEN  = 250,
  parameter int BLOCK_BYTES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  output logic       tone_out,
  output logic       tx_busy,
  input  logic       tone_in,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       block_done,
  output logic       crc_error,
  output logic       rx_abort
);
  logic bit_v, bit_val, stall;

  cas_tx #(
    .BIT_CYC(BIT_CYC), .LEADER_LEN(LEADER_LEN), .BLOCK_BYTES(BLOCK_BYTES)
  ) i_tx (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .tone_out(tone_out), .busy(tx_busy)
  );

  cas_bitdet #(.BIT_CYC(BIT_CYC)) i_bitdet (
    .clk(clk), .rst_n(rst_n), .tone_in(tone_in),
    .bit_v(bit_v), .bit_val(bit_val), .stall(stall)
  );

  cas_rxframe #(.LEADER_LEN(LEADER_LEN), .BLOCK_BYTES(BLOCK_BYTES)) i_rxframe (
    .clk(clk), .rst_n(rst_n), .bit_v(bit_v), .bit_val(bit_val), .stall(stall),
    .m_valid(m_valid), .m_data(m_data), .block_done(block_done),
    .crc_error(crc_error), .rx_abort(rx_abort)
  );

endmodule

// File: rtl/cas_codec_chk.sv
module cas_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic tone_out,
  input logic tx_busy,
  input logic m_valid,
  input logic block_done,
  input logic crc_error,
  input logic rx_abort
);
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !tone_out); // R4
  AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !tx_busy) |-> ##2 tx_busy); // R4
  AST_ERR_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error |-> block_done); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> !block_done); // R8
  AST_BYTE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |=> !m_valid); // R7
  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |-> !block_done); // R9
endmodule

bind cas_codec cas_codec_chk i_chk (.*);

// File: tb/test_cas_codec.sv
module test_cas_codec;
  localparam int BC = 6;
  localparam int TH = BC / 3;
  localparam int LL = 8;
  localparam int NB = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, s_valid, loop_en, man_tone;
  logic [7:0] s_data;
  wire  s_ready, tone_out, tx_busy, m_valid, block_done, crc_error, rx_abort;
  wire  [7:0] m_data;
  wire  tone_in = loop_en ? tone_out : man_tone;

  cas_codec #(.BIT_CYC(BC), .LEADER_LEN(LL), .BLOCK_BYTES(NB)) i_cas_codec (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .tone_out(tone_out), .tx_busy(tx_busy), .tone_in(tone_in), .m_valid(m_valid),
    .m_data(m_data), .block_done(block_done), .crc_error(crc_error), .rx_abort(rx_abort)
  );

  int checks = 0, errors = 0;
  int n_done = 0, n_abort = 0, n_bytes = 0;
  logic [7:0] exp_q[$];
  logic       exp_err_q[$];
  logic [7:0] blk[NB];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ d[i];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_valid) begin
        n_bytes++;
        if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected byte", m_data, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(m_data == e, "R7", "decoded byte", m_data, e);
        end
      end
      if (block_done) begin
        n_done++;
        if (exp_err_q.size() == 0) chk(1'b0, "R8", "unexpected block_done", 1, 0);
        else begin
          logic ee;
          ee = exp_err_q.pop_front();
          chk(crc_error == ee, "R8", "crc_error at block end", crc_error, ee);
        end
      end
      if (rx_abort) n_abort++;
    end
  end

  task automatic push(input logic [7:0] d);
    s_data  = d;
    s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic meas(output int hi, output int lo);
    while (!tone_out) @(negedge clk);
    hi = 0;
    while (tone_out) begin hi++; @(negedge clk); end
    lo = 0;
    while (!tone_out && lo < 100) begin lo++; @(negedge clk); end
  endtask

  task automatic man_bit(input bit b, input int th);
    man_tone = 1'b1; repeat (th) @(negedge clk);
    man_tone = b;    repeat (th) @(negedge clk);
    man_tone = 1'b0; repeat (th) @(negedge clk);
  endtask

  task automatic man_byte(input logic [7:0] d, input int th);
    for (int i = 0; i < 8; i++) man_bit(d[i], th);
  endtask

  // hand-built block from blk[]; corrupt flips one checksum bit
  task automatic man_block(input int th, input bit corrupt, input int lead);
    logic [15:0] c;
    c = 16'h0000;
    for (int i = 0; i < lead; i++) man_bit(1'b1, th);
    man_bit(1'b0, th);
    for (int i = 0; i < NB; i++) begin
      man_byte(blk[i], th);
      c = ref_crc(c, blk[i]);
    end
    man_byte(c[7:0] ^ {7'd0, corrupt}, th);
    man_byte(c[15:8], th);
    man_tone = 1'b1; repeat (th) @(negedge clk);
    man_tone = 1'b0; repeat (3 * th + 8) @(negedge clk);
  endtask

  task automatic expect_block(input logic err);
    for (int i = 0; i < NB; i++) exp_q.push_back(blk[i]);
    exp_err_q.push_back(err);
  endtask

  task automatic loop_block();
    for (int i = 0; i < NB; i++) push(blk[i]);
    chk(s_ready == 1'b0 && tx_busy == 1'b1, "R4", "s_ready low after last byte", s_ready, 0);
    while (tx_busy) begin
      chk(s_ready == 1'b0, "R4", "s_ready held low in block", s_ready, 0);
      @(negedge clk);
    end
    chk(s_ready == 1'b1, "R4", "s_ready back after block", s_ready, 1);
    repeat (12) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    int hi, lo, nd, nbt;
    rst_n = 1'b0; s_valid = 1'b0; s_data = 8'h00; loop_en = 1'b1; man_tone = 1'b0;
    repeat (3) @(negedge clk);
    chk(s_ready == 1'b1, "R10", "s_ready in reset", s_ready, 1);
    chk({tone_out, tx_busy, m_valid, block_done, crc_error, rx_abort} == 6'd0,
        "R10", "outputs low in reset", {tone_out, tx_busy, m_valid, block_done, crc_error, rx_abort}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // loopback block with waveform shape checks (R1, R2, R3)
    blk = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    expect_block(1'b0);
    fork
      loop_block();
      begin
        for (int i = 0; i < LL; i++) begin
          meas(hi, lo);
          chk(hi == 2 * TH && lo == TH, "R1", "leader one-bit tone/pause", hi * 100 + lo, 2 * TH * 100 + TH);
        end
        meas(hi, lo);
        chk(hi == TH && lo == 2 * TH, "R2", "zero marker tone/pause", hi * 100 + lo, TH * 100 + 2 * TH);
        meas(hi, lo);
        chk(hi == TH && lo == 2 * TH, "R2", "first data bit of 0x00", hi * 100 + lo, TH * 100 + 2 * TH);
      end
    join
    chk(n_done == 1, "R3", "loopback block completed clean", n_done, 1);

    blk = '{8'h12, 8'h80, 8'h01, 8'hFE};
    expect_block(1'b0);
    loop_block();
    chk(n_done == 2 && exp_q.size() == 0, "R2", "second loopback block", n_done, 2);

    // hand-built waveforms at other speeds (R5)
    loop_en = 1'b0;
    blk = '{8'hC3, 8'h5A, 8'h00, 8'hFF};
    expect_block(1'b0);
    man_block(7, 1'b0, LL);
    chk(n_done == 3 && exp_q.size() == 0, "R5", "slow tape thirds 7", n_done, 3);

    blk = '{8'h11, 8'h22, 8'h33, 8'h44};
    expect_block(1'b1);
    man_block(3, 1'b1, LL);
    chk(n_done == 4 && exp_q.size() == 0, "R8", "corrupt checksum flagged", n_done, 4);
    chk(n_abort == 0, "R9", "no abort from idle gaps", n_abort, 0);

    // leader one short: zero restarts search, nothing decoded (R6)
    nd = n_done; nbt = n_bytes;
    blk = '{8'h00, 8'h00, 8'h00, 8'h00};
    man_block(3, 1'b0, LL - 1);
    chk(n_bytes == nbt, "R6", "short leader gives no bytes", n_bytes, nbt);
    chk(n_done == nd, "R6", "short leader gives no block", n_done, nd);
    chk(n_abort == 0, "R9", "no abort while hunting", n_abort, 0);

    // junk ones, zero, then full block: still accepted (R6)
    for (int i = 0; i < LL - 3; i++) man_bit(1'b1, 3);
    man_bit(1'b0, 3);
    blk = '{8'h5A, 8'hA5, 8'h0F, 8'hF0};
    expect_block(1'b0);
    man_block(3, 1'b0, LL);
    chk(n_done == nd + 1, "R6", "block after restarted leader", n_done, nd + 1);

    // cut-off block: abort after silence (R9)
    nd = n_done;
    for (int i = 0; i < LL; i++) man_bit(1'b1, 3);
    man_bit(1'b0, 3);
    exp_q.push_back(8'hA5);
    man_byte(8'hA5, 3);
    man_bit(1'b1, 3);
    repeat (6 * BC) @(negedge clk);
    chk(n_abort == 1, "R9", "abort pulses after gap", n_abort, 1);
    chk(n_done == nd && exp_q.size() == 0, "R9", "no block_done on abort", n_done, nd);

    // recovery after abort
    blk = '{8'h01, 8'h02, 8'h04, 8'h08};
    expect_block(1'b0);
    man_block(5, 1'b0, LL);
    chk(n_done == nd + 1 && exp_q.size() == 0, "R7", "block after abort", n_done, nd + 1);

    summary();
    $finish;
  end

endmodule